// File: doc/BRIEF.md
# Pulse Period and Width Capture Timer

This block times an external pulse with a 16-bit counter. The counter advances once per clock in which the count-enable strobe is high. When a selected edge of the measurement input arrives, the running count is copied into a holding register and the counter starts again from zero. One mode measures the full period between falling edges. The other mode measures each high phase and each low phase in turn, so every edge closes one interval.

Software sets a start bit to arm the timer. A capture raises an interrupt-request flag. That flag stays set until it is acknowledged or cleared. The first capture after start is marked not valid, because no complete interval lies behind it. A sticky overflow flag shows that the counter wrapped inside an interval. Writing the mode or pulsing the overflow clear resets that flag.

Top module: `pulse_capture_timer`

## Requirements
- R1: After reset, capValue is 0 and capValid, ovfFlag and irqFlag are all 0. The mode register holds 2'b00.
- R2: In mode 2'b00 only falling edges of measIn capture. With cntEn held high, two falling edges N cycles apart yield capValue = N.
- R3: In mode 2'b10 every edge of measIn captures. With cntEn held high, the value is the number of cycles since the previous edge, which gives the high and low widths in turn.
- R4: The counter advances only in cycles where cntEn is high. A capture cycle counts as the first cycle of the new interval.
- R5: The first capture after startBit goes from 0 to 1 gives capValid = 0. Each later capture while startBit stays 1 gives capValid = 1.
- R6: A capture sets irqFlag. irqFlag stays 1 until irqClr is high at a clock edge. If a capture and irqClr arrive together, the capture wins.
- R7: ovfFlag is set when the counter wraps from all-ones to zero during a measurement. Captures do not clear it. ovfClr or modeWrite clears it, and a clear wins over a wrap in the same cycle.
- R8: While startBit is 0 the counter is frozen and no capture happens. capValue, capValid and irqFlag keep their values.
- R9: Modes 2'b01 and 2'b11 are reserved. They make no capture and leave capValue and irqFlag untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cntEn | input | 1 | Count-source enable strobe, one count per high cycle |
| measIn | input | 1 | Asynchronous measurement pulse |
| startBit | input | 1 | Run control; 1 counts and allows captures |
| modeSel | input | 2 | Mode value, loaded on modeWrite (00 period, 10 both edges) |
| modeWrite | input | 1 | Loads modeSel into the mode register and clears ovfFlag |
| ovfClr | input | 1 | Clears ovfFlag |
| irqClr | input | 1 | Interrupt acknowledge or software clear of irqFlag |
| capValue | output | 16 | Last captured count |
| capValid | output | 1 | 1 when capValue covers a complete interval |
| ovfFlag | output | 1 | Sticky counter-wrap flag |
| irqFlag | output | 1 | Capture interrupt request |

## Verification
Falling-edge periods with unequal high and low phases show that mode 2'b00 ignores rising edges. The same input pattern in mode 2'b10 shows that each half is captured on its own. Gating cntEn to every other cycle over a known window separates counting of enable strobes from counting of clocks. Intervals longer than the counter range give a known wrapped residue together with the sticky flag. Edges applied while stopped or in a reserved mode must produce no capture event at all.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;
  typedef enum logic [1:0] {
    MODE_FALL  = 2'b00,
    MODE_RSVD1 = 2'b01,
    MODE_BOTH  = 2'b10,
    MODE_RSVD3 = 2'b11
  } meas_mode_e;

  typedef struct packed {
    logic countEn;
    logic capture;
    logic firstDone;
    logic ovfClear;
  } dp_strobe_t;
endpackage

// File: rtl/pct_ctrl.sv
`timescale 1ns/1ps
module pct_ctrl
  import pct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cntEn,
  input  logic       measIn,
  input  logic       startBit,
  input  logic [1:0] modeSel,
  input  logic       modeWrite,
  input  logic       ovfClr,
  input  logic       irqClr,
  output dp_strobe_t strobes,
  output logic       irqFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  meas_mode_e modeQ;
  logic [LAST:0] syncQ;
  logic prevQ;
  logic capStbQ;
  logic seenFirstQ;
  logic irqQ;
  logic sampled, fallEdge, riseEdge, edgeHit, capture;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_FALL;
    else if (modeWrite) modeQ <= meas_mode_e'(modeSel);
  end

  // Synchronizer chain followed by an edge register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[LAST-1:0], measIn};
      prevQ <= sampled;
    end
  end

  assign sampled  = syncQ[LAST];
  assign fallEdge = prevQ & ~sampled;
  assign riseEdge = ~prevQ & sampled;

  always_comb begin
    case (modeQ)
      MODE_FALL: edgeHit = fallEdge;
      MODE_BOTH: edgeHit = fallEdge | riseEdge;
      default:   edgeHit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capStbQ <= 1'b0;
    else       capStbQ <= edgeHit & startBit;
  end

  assign capture = capStbQ & startBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          seenFirstQ <= 1'b0;
    else if (!startBit) seenFirstQ <= 1'b0;
    else if (capture)   seenFirstQ <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        irqQ <= 1'b0;
    else if (capture) irqQ <= 1'b1;
    else if (irqClr)  irqQ <= 1'b0;
  end

  assign irqFlag           = irqQ;
  assign strobes.countEn   = startBit & cntEn;
  assign strobes.capture   = capture;
  assign strobes.firstDone = seenFirstQ;
  assign strobes.ovfClear  = ovfClr | modeWrite;
endmodule

// File: rtl/pct_datapath.sv
`timescale 1ns/1ps
module pct_datapath
  import pct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dp_strobe_t       strobes,
  output logic [CNT_W-1:0] capValue,
  output logic             capValid,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] capQ;
  logic validQ, ovfQ, wrapHit;

  assign wrapHit = strobes.countEn & ~strobes.capture & (countQ == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  countQ <= '0;
    else if (strobes.capture)   countQ <= strobes.countEn ? CNT_ONE : '0;
    else if (strobes.countEn)   countQ <= countQ + CNT_ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capQ   <= '0;
      validQ <= 1'b0;
    end else if (strobes.capture) begin
      capQ   <= countQ;
      validQ <= strobes.firstDone;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 ovfQ <= 1'b0;
    else if (strobes.ovfClear) ovfQ <= 1'b0;
    else if (wrapHit)          ovfQ <= 1'b1;
  end

  assign capValue = capQ;
  assign capValid = validQ;
  assign ovfFlag  = ovfQ;
endmodule

// File: rtl/pulse_capture_timer.sv
`timescale 1ns/1ps
module pulse_capture_timer
  import pct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic             measIn,
  input  logic             startBit,
  input  logic [1:0]       modeSel,
  input  logic             modeWrite,
  input  logic             ovfClr,
  input  logic             irqClr,
  output logic [CNT_W-1:0] capValue,
  output logic             capValid,
  output logic             ovfFlag,
  output logic             irqFlag
);
  dp_strobe_t strobes;

  pct_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .measIn(measIn),
    .startBit(startBit), .modeSel(modeSel), .modeWrite(modeWrite),
    .ovfClr(ovfClr), .irqClr(irqClr), .strobes(strobes), .irqFlag(irqFlag)
  );

  pct_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .capValue(capValue), .capValid(capValid), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/pct_checker.sv
`timescale 1ns/1ps
module pct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startBit,
  input logic             modeWrite,
  input logic             ovfClr,
  input logic             irqClr,
  input logic [CNT_W-1:0] capValue,
  input logic             capValid,
  input logic             ovfFlag,
  input logic             irqFlag
);
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |=> ($stable(capValue) && $stable(capValid))); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqClr) |=> irqFlag); // R6

  AST_CAPTURE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(capValue) |-> irqFlag); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr && !modeWrite) |=> ovfFlag); // R7

  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ovfClr || modeWrite) |=> !ovfFlag); // R7
endmodule

bind pulse_capture_timer pct_checker #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .startBit(startBit), .modeWrite(modeWrite),
  .ovfClr(ovfClr), .irqClr(irqClr), .capValue(capValue),
  .capValid(capValid), .ovfFlag(ovfFlag), .irqFlag(irqFlag)
);

// File: tb/tb_pulse_capture_timer.sv
`timescale 1ns/1ps
module tb_pulse_capture_timer;
  typedef struct {
    logic [15:0] val;
    logic        vld;
    logic        chkVal;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, measIn = 1'b1, startBit = 1'b0, modeWrite = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic ovfClr = 1'b0, swClr = 1'b0, monClr = 1'b0;
  logic halfRate = 1'b0, phase = 1'b0, autoAck = 1'b1, irqPrev = 1'b0;
  logic cntEn, irqClr;
  logic [15:0] capValue;
  logic capValid, ovfFlag, irqFlag;
  int nChecks = 0, nFail = 0;
  string phaseReq = "R2";
  exp_t q[$];

  assign cntEn  = halfRate ? phase : 1'b1;
  assign irqClr = monClr | swClr;
  always @(negedge clk) phase <= ~phase;

  pulse_capture_timer dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .measIn(measIn),
    .startBit(startBit), .modeSel(modeSel), .modeWrite(modeWrite),
    .ovfClr(ovfClr), .irqClr(irqClr), .capValue(capValue),
    .capValid(capValid), .ovfFlag(ovfFlag), .irqFlag(irqFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectCap(input logic [15:0] v, input logic vld, input logic chk, input string req);
    exp_t it;
    it.val = v; it.vld = vld; it.chkVal = chk; it.req = req;
    q.push_back(it);
  endtask

  task automatic writeMode(input logic [1:0] m);
    modeSel = m; modeWrite = 1'b1;
    cyc(1);
    modeWrite = 1'b0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  // Monitor: compares each capture event against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      monClr = 1'b0;
      if (rstN && irqFlag && !irqPrev) begin
        if (q.size() == 0) begin
          check({phaseReq, " unexpected capture"}, 32'd1, 32'd0);
        end else begin
          exp_t it;
          it = q.pop_front();
          if (it.chkVal) check({it.req, " capValue"}, capValue, it.val);
          check({it.req, " capValid"}, capValid, it.vld);
        end
        if (autoAck) monClr = 1'b1;
      end
      irqPrev = irqFlag;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    check("R1 capValue", capValue, 0);
    check("R1 capValid", capValid, 0);
    check("R1 ovfFlag", ovfFlag, 0);
    check("R1 irqFlag", irqFlag, 0);

    // R2 period mode with unequal phases
    writeMode(2'b00);
    startBit = 1'b1; cyc(10);
    measIn = 1'b0; expectCap(16'd0, 1'b0, 1'b0, "R5 first after start");
    cyc(20); measIn = 1'b1;
    cyc(17); measIn = 1'b0; expectCap(16'd37, 1'b1, 1'b1, "R2 period");
    cyc(25); measIn = 1'b1;
    cyc(15); measIn = 1'b0; expectCap(16'd40, 1'b1, 1'b1, "R2 period");
    cyc(12);

    // R4 half-rate count source
    phaseReq = "R4";
    halfRate = 1'b1; cyc(6);
    measIn = 1'b1; cyc(10);
    measIn = 1'b0; expectCap(16'd0, 1'b1, 1'b0, "R4 lead-in");
    cyc(20); measIn = 1'b1;
    cyc(20); measIn = 1'b0; expectCap(16'd20, 1'b1, 1'b1, "R4 gated count");
    cyc(12); halfRate = 1'b0;

    // R3 both-edge mode
    phaseReq = "R3";
    startBit = 1'b0; cyc(3);
    writeMode(2'b10);
    startBit = 1'b1; cyc(10);
    measIn = 1'b1; expectCap(16'd0, 1'b0, 1'b0, "R5 first after restart");
    cyc(14); measIn = 1'b0; expectCap(16'd14, 1'b1, 1'b1, "R3 high width");
    cyc(9);  measIn = 1'b1; expectCap(16'd9, 1'b1, 1'b1, "R3 low width");
    cyc(21); measIn = 1'b0; expectCap(16'd21, 1'b1, 1'b1, "R3 high width");
    cyc(12);

    // R8 stopped: edges ignored, value kept
    phaseReq = "R8";
    startBit = 1'b0; cyc(3);
    for (int i = 0; i < 4; i++) begin measIn = ~measIn; cyc(8); end
    cyc(10);
    check("R8 capValue held", capValue, 21);
    check("R8 capValid held", capValid, 1);
    check("R8 irqFlag", irqFlag, 0);

    // R9 reserved modes
    phaseReq = "R9";
    writeMode(2'b01);
    startBit = 1'b1; cyc(5);
    for (int i = 0; i < 4; i++) begin measIn = ~measIn; cyc(8); end
    cyc(10);
    check("R9 mode 01 capValue", capValue, 21);
    check("R9 mode 01 irqFlag", irqFlag, 0);
    writeMode(2'b11);
    for (int i = 0; i < 4; i++) begin measIn = ~measIn; cyc(8); end
    cyc(10);
    check("R9 mode 11 capValue", capValue, 21);
    check("R9 mode 11 irqFlag", irqFlag, 0);
    measIn = 1'b1; cyc(5);

    // R7 overflow
    phaseReq = "R7";
    startBit = 1'b0; cyc(2);
    writeMode(2'b00);
    check("R7 ovf clear before run", ovfFlag, 0);
    startBit = 1'b1; cyc(5);
    measIn = 1'b0; expectCap(16'd0, 1'b0, 1'b0, "R5 first before overflow");
    cyc(100); measIn = 1'b1;
    cyc(69900); measIn = 1'b0; expectCap(16'd4464, 1'b1, 1'b1, "R7 wrapped residue");
    cyc(12);
    check("R7 ovf set", ovfFlag, 1);
    cyc(8); measIn = 1'b1;
    cyc(10); measIn = 1'b0; expectCap(16'd30, 1'b1, 1'b1, "R7 short after wrap");
    cyc(12);
    check("R7 ovf sticky over capture", ovfFlag, 1);
    ovfClr = 1'b1; cyc(1); ovfClr = 1'b0;
    check("R7 ovf cleared by ovfClr", ovfFlag, 0);
    cyc(37); measIn = 1'b1;
    cyc(65950); measIn = 1'b0; expectCap(16'd464, 1'b1, 1'b1, "R7 second wrap");
    cyc(12);
    check("R7 ovf set again", ovfFlag, 1);
    writeMode(2'b00);
    check("R7 ovf cleared by mode write", ovfFlag, 0);

    // R6 interrupt flag holds until cleared
    phaseReq = "R6";
    autoAck = 1'b0; cyc(5);
    measIn = 1'b1; cyc(10);
    measIn = 1'b0; expectCap(16'd0, 1'b1, 1'b0, "R6 capture");
    cyc(30);
    check("R6 irq held", irqFlag, 1);
    swClr = 1'b1; cyc(1); swClr = 1'b0;
    check("R6 irq cleared", irqFlag, 0);
    autoAck = 1'b1;

    cyc(5);
    check("R2 all expected captures seen", q.size(), 0);
    finishRun();
  end
endmodule